// File: doc/BRIEF.md
# Frame Timestamp Timer

This block keeps a 16-bit up-counter for a serial bus controller. The counter runs in the bus bit-clock domain and advances by one for each bit time that the bit-timing logic signals. During a frame that is one tick per bit sent or received. While the bus is idle the ticks still arrive at the programmed rate. A freeze input stops the counter. When the protocol engine marks the start of a frame's identifier field, the block latches the counter. When the engine later reports that the frame completed successfully, the block presents the latched value as that frame's timestamp for the message store. A frame that never reports success produces no timestamp.

The host works in its own clock domain. It reads the counter through a gray-coded copy that passes through two synchronizing flops. It loads a new counter value by writing to an auxiliary register. A toggle request crosses into the bit-clock domain and the counter takes the value there. A toggle acknowledge then returns, and the host sees a busy flag until it arrives. Software can also poll the read path until the new value appears.

Top module: `frame_stamp_timer`

## Requirements
- R1: After reset the counter, `host_rd_data` and `host_wr_busy` are all 0, and `stamp_valid` is low.
- R2: On each `bit_clk` edge where `bit_tick` is 1 and `freeze` is 0, the counter increases by exactly one. With `bit_tick` at 0 it keeps its value.
- R3: From 0xFFFF the counter wraps to 0x0000 on the next counted tick.
- R4: While `freeze` is 1, ticks are not counted and the counter keeps its value.
- R5: A one-cycle `id_start` latches the counter value of that `bit_clk` cycle, before that cycle's increment.
- R6: A one-cycle `frame_ok` causes `stamp_valid` to be high for exactly the following `bit_clk` cycle, with `stamp_value` equal to the most recent latched value. A frame with `id_start` but no `frame_ok` raises no `stamp_valid`.
- R7: A host write accepted while `host_wr_busy` is 0 raises `host_wr_busy` on the next `cpu_clk` cycle. The flag stays high until the acknowledge returns, and the counter then holds the written value.
- R8: A host write issued while `host_wr_busy` is 1 is ignored: the counter ends with the first written value.
- R9: A loaded value takes priority over a tick in the same `bit_clk` cycle, so that tick is dropped. A load also takes effect while `freeze` is 1.
- R10: `host_rd_data` follows the counter through a two-flop synchronized gray copy. Once the counter is stable, `host_rd_data` equals it within a few `cpu_clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Host clock |
| cpu_rst_n | input | 1 | Host-domain reset, active low |
| host_wr_en | input | 1 | One-cycle write strobe for the counter |
| host_wr_data | input | 16 | Value to load into the counter |
| host_rd_data | output | 16 | Synchronized counter value |
| host_wr_busy | output | 1 | High from an accepted write until its acknowledge returns |
| bit_clk | input | 1 | Bit-timing clock |
| bit_rst_n | input | 1 | Bit-domain reset, active low |
| bit_tick | input | 1 | One bit time has elapsed |
| freeze | input | 1 | Stops the counter |
| id_start | input | 1 | Start of the identifier field of a frame |
| frame_ok | input | 1 | The frame completed successfully |
| stamp_valid | output | 1 | Timestamp is available this cycle |
| stamp_value | output | 16 | Timestamp of the completed frame |

## Verification
The hardest case to reach is a load that lands in a bit-clock cycle that also carries a tick. The bench holds `bit_tick` high on every bit cycle from before the host write until after the busy flag drops, so the load cycle is certain to carry a tick. It counts the ticks applied and checks that the final counter lies strictly below the written value plus that count. The checker confirms the exact cycle. A second case is a write issued one host cycle after another, which lands while the first handshake is still in flight.

// File: rtl/fst_pkg.sv
package fst_pkg;
    localparam int unsigned SYNC_DEPTH = 2;
    localparam int unsigned CNT_WIDTH  = 16;
endpackage

// File: rtl/fst_sync.sv
module fst_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/fst_cpu_port.sv
module fst_cpu_port #(
    parameter int unsigned W = 16
) (
    input  logic         cpu_clk,
    input  logic         cpu_rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         ack_lvl,
    output logic [W-1:0] aux_o,
    output logic         req_lvl_o,
    output logic         busy_o
);
    import fst_pkg::*;

    typedef struct packed {
        logic [W-1:0] aux;
        logic         req;
    } cpu_st_t;

    cpu_st_t st_d, st_q;
    logic    ack_s;
    logic    busy;

    fst_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_ack_sync (
        .clk   (cpu_clk),
        .rst_n (cpu_rst_n),
        .d     (ack_lvl),
        .q     (ack_s)
    );

    assign busy = st_q.req ^ ack_s;

    always_comb begin
        st_d = st_q;
        if (wr_en && !busy) begin
            st_d.aux = wr_data;
            st_d.req = ~st_q.req;
        end
    end

    always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
        if (!cpu_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign aux_o     = st_q.aux;
    assign req_lvl_o = st_q.req;
    assign busy_o    = busy;
endmodule

// File: rtl/fst_bit_core.sv
module fst_bit_core #(
    parameter int unsigned W = 16
) (
    input  logic         bit_clk,
    input  logic         bit_rst_n,
    input  logic         tick,
    input  logic         freeze,
    input  logic         id_start,
    input  logic         frame_ok,
    input  logic         req_lvl,
    input  logic [W-1:0] aux,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] gray_o,
    output logic         ack_lvl_o,
    output logic         load_o,
    output logic         stamp_valid_o,
    output logic [W-1:0] stamp_o
);
    import fst_pkg::*;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] gray;
        logic [W-1:0] cap;
        logic [W-1:0] stamp;
        logic         stamp_vld;
        logic         req_seen;
    } bit_st_t;

    bit_st_t st_d, st_q;
    logic    req_s;
    logic    load;

    fst_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_req_sync (
        .clk   (bit_clk),
        .rst_n (bit_rst_n),
        .d     (req_lvl),
        .q     (req_s)
    );

    assign load = req_s ^ st_q.req_seen;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt      = aux;
            st_d.req_seen = req_s;
        end else if (tick && !freeze) begin
            st_d.cnt = st_q.cnt + {{(W-1){1'b0}}, 1'b1};
        end
        st_d.gray = st_d.cnt ^ (st_d.cnt >> 1);
        if (id_start) st_d.cap = st_q.cnt;
        st_d.stamp_vld = frame_ok;
        if (frame_ok) st_d.stamp = st_q.cap;
    end

    always_ff @(posedge bit_clk or negedge bit_rst_n) begin
        if (!bit_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign cnt_o         = st_q.cnt;
    assign gray_o        = st_q.gray;
    assign ack_lvl_o     = st_q.req_seen;
    assign load_o        = load;
    assign stamp_valid_o = st_q.stamp_vld;
    assign stamp_o       = st_q.stamp;
endmodule

// File: rtl/fst_gray_rx.sv
module fst_gray_rx #(
    parameter int unsigned W = 16
) (
    input  logic         cpu_clk,
    input  logic         cpu_rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_o
);
    import fst_pkg::*;

    logic [W-1:0] gray_s;

    fst_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_gray_sync (
        .clk   (cpu_clk),
        .rst_n (cpu_rst_n),
        .d     (gray_in),
        .q     (gray_s)
    );

    always_comb begin
        for (int i = 0; i < W; i++) bin_o[i] = ^(gray_s >> i);
    end
endmodule

// File: rtl/frame_stamp_timer.sv
module frame_stamp_timer #(
    parameter int unsigned W = fst_pkg::CNT_WIDTH
) (
    input  logic         cpu_clk,
    input  logic         cpu_rst_n,
    input  logic         host_wr_en,
    input  logic [W-1:0] host_wr_data,
    output logic [W-1:0] host_rd_data,
    output logic         host_wr_busy,
    input  logic         bit_clk,
    input  logic         bit_rst_n,
    input  logic         bit_tick,
    input  logic         freeze,
    input  logic         id_start,
    input  logic         frame_ok,
    output logic         stamp_valid,
    output logic [W-1:0] stamp_value
);
    logic [W-1:0] aux_w;
    logic         req_w;
    logic         ack_w;
    logic [W-1:0] cnt_w;
    logic [W-1:0] gray_w;
    logic         load_w;

    fst_cpu_port #(.W(W)) u_cpu (
        .cpu_clk   (cpu_clk),
        .cpu_rst_n (cpu_rst_n),
        .wr_en     (host_wr_en),
        .wr_data   (host_wr_data),
        .ack_lvl   (ack_w),
        .aux_o     (aux_w),
        .req_lvl_o (req_w),
        .busy_o    (host_wr_busy)
    );

    fst_bit_core #(.W(W)) u_core (
        .bit_clk       (bit_clk),
        .bit_rst_n     (bit_rst_n),
        .tick          (bit_tick),
        .freeze        (freeze),
        .id_start      (id_start),
        .frame_ok      (frame_ok),
        .req_lvl       (req_w),
        .aux           (aux_w),
        .cnt_o         (cnt_w),
        .gray_o        (gray_w),
        .ack_lvl_o     (ack_w),
        .load_o        (load_w),
        .stamp_valid_o (stamp_valid),
        .stamp_o       (stamp_value)
    );

    fst_gray_rx #(.W(W)) u_rd (
        .cpu_clk   (cpu_clk),
        .cpu_rst_n (cpu_rst_n),
        .gray_in   (gray_w),
        .bin_o     (host_rd_data)
    );
endmodule

// File: rtl/fst_checks.sv
module fst_checks #(
    parameter int unsigned W = 16
) (
    input logic         bit_clk,
    input logic         bit_rst_n,
    input logic         cpu_clk,
    input logic         cpu_rst_n,
    input logic         tick,
    input logic         freeze,
    input logic         frame_ok,
    input logic         load,
    input logic [W-1:0] aux,
    input logic [W-1:0] cnt,
    input logic         stamp_valid,
    input logic         wr_en,
    input logic         wr_busy
);
    // R2
    tick_inc_chk: assert property (@(posedge bit_clk) disable iff (!bit_rst_n)
        (tick && !freeze && !load) |=> cnt == ($past(cnt) + {{(W-1){1'b0}}, 1'b1}));

    // R4
    freeze_hold_chk: assert property (@(posedge bit_clk) disable iff (!bit_rst_n)
        (freeze && !load) |=> $stable(cnt));

    // R9
    load_wins_chk: assert property (@(posedge bit_clk) disable iff (!bit_rst_n)
        load |=> cnt == $past(aux));

    // R6
    stamp_pulse_chk: assert property (@(posedge bit_clk) disable iff (!bit_rst_n)
        frame_ok |=> stamp_valid);

    // R6
    no_stamp_chk: assert property (@(posedge bit_clk) disable iff (!bit_rst_n)
        !frame_ok |=> !stamp_valid);

    // R7
    busy_rise_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        (wr_en && !wr_busy) |=> wr_busy);
endmodule

bind frame_stamp_timer fst_checks #(.W(W)) u_chk (
    .bit_clk     (bit_clk),
    .bit_rst_n   (bit_rst_n),
    .cpu_clk     (cpu_clk),
    .cpu_rst_n   (cpu_rst_n),
    .tick        (bit_tick),
    .freeze      (freeze),
    .frame_ok    (frame_ok),
    .load        (load_w),
    .aux         (aux_w),
    .cnt         (cnt_w),
    .stamp_valid (stamp_valid),
    .wr_en       (host_wr_en),
    .wr_busy     (host_wr_busy)
);

// File: tb/frame_stamp_timer_tb.sv
`timescale 1ns/1ps
module frame_stamp_timer_tb;
    logic        cpu_clk = 0;
    logic        bit_clk = 0;
    logic        cpu_rst_n = 0;
    logic        bit_rst_n = 0;
    logic        host_wr_en = 0;
    logic [15:0] host_wr_data = '0;
    logic [15:0] host_rd_data;
    logic        host_wr_busy;
    logic        bit_tick = 0;
    logic        freeze = 0;
    logic        id_start = 0;
    logic        frame_ok = 0;
    logic        stamp_valid;
    logic [15:0] stamp_value;

    int          n_chk = 0;
    int          n_bad = 0;
    int          stamp_seen = 0;
    logic [15:0] last_stamp = '0;
    logic [15:0] exp_cnt = '0;

    always #10 cpu_clk = ~cpu_clk;
    always #17 bit_clk = ~bit_clk;

    frame_stamp_timer u_dut (
        .cpu_clk      (cpu_clk),
        .cpu_rst_n    (cpu_rst_n),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .host_rd_data (host_rd_data),
        .host_wr_busy (host_wr_busy),
        .bit_clk      (bit_clk),
        .bit_rst_n    (bit_rst_n),
        .bit_tick     (bit_tick),
        .freeze       (freeze),
        .id_start     (id_start),
        .frame_ok     (frame_ok),
        .stamp_valid  (stamp_valid),
        .stamp_value  (stamp_value)
    );

    always @(negedge bit_clk) begin
        if (stamp_valid) begin
            stamp_seen++;
            last_stamp = stamp_value;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        @(negedge bit_clk);
        bit_tick = 1;
        repeat (n) @(negedge bit_clk);
        bit_tick = 0;
        if (!freeze) exp_cnt = exp_cnt + 16'(n);
    endtask

    task automatic host_write(input logic [15:0] v);
        @(negedge cpu_clk);
        host_wr_en   = 1;
        host_wr_data = v;
        @(negedge cpu_clk);
        host_wr_en = 0;
    endtask

    task automatic settle();
        while (host_wr_busy) @(negedge cpu_clk);
        repeat (4) @(negedge bit_clk);
        repeat (6) @(negedge cpu_clk);
    endtask

    task automatic pulse_id();
        @(negedge bit_clk); id_start = 1;
        @(negedge bit_clk); id_start = 0;
    endtask

    task automatic pulse_ok();
        @(negedge bit_clk); frame_ok = 1;
        @(negedge bit_clk); frame_ok = 0;
    endtask

    task automatic t_reset();
        chk("R1 rd", host_rd_data, 0);
        chk("R1 busy", host_wr_busy, 0);
        chk("R1 stamp", stamp_valid, 0);
    endtask

    task automatic t_count();
        ticks(10); settle();
        chk("R2 ten ticks", host_rd_data, exp_cnt);
        ticks(5); settle();
        chk("R10 read path", host_rd_data, exp_cnt);
    endtask

    task automatic t_freeze();
        freeze = 1;
        ticks(10); settle();
        chk("R4 frozen", host_rd_data, exp_cnt);
        freeze = 0;
    endtask

    task automatic t_write();
        host_write(16'h1234);
        chk("R7 busy", host_wr_busy, 1);
        host_write(16'hBEEF);
        settle();
        exp_cnt = 16'h1234;
        chk("R7 loaded", host_rd_data, exp_cnt);
        chk("R8 second write ignored", host_rd_data, 16'h1234);
        chk("R7 busy cleared", host_wr_busy, 0);
    endtask

    task automatic t_wrap();
        host_write(16'hFFFD); settle();
        exp_cnt = 16'hFFFD;
        ticks(5); settle();
        chk("R3 wrap", host_rd_data, 16'h0002);
    endtask

    task automatic t_stamp();
        int base;
        logic [15:0] c0;
        c0 = exp_cnt;
        base = stamp_seen;
        pulse_id();
        ticks(7);
        pulse_ok();
        repeat (2) @(negedge bit_clk);
        chk("R6 one stamp", stamp_seen - base, 1);
        chk("R5 captured", last_stamp, c0);
        base = stamp_seen;
        pulse_id();
        ticks(3);
        repeat (4) @(negedge bit_clk);
        chk("R6 failed frame no stamp", stamp_seen - base, 0);
        c0 = exp_cnt;
        pulse_id();
        ticks(2);
        pulse_ok();
        repeat (2) @(negedge bit_clk);
        chk("R5 new capture", last_stamp, c0);
    endtask

    task automatic t_load_prio();
        int  t;
        bit  done;
        logic [15:0] r;
        freeze = 1;
        host_write(16'h4000); settle();
        chk("R9 load under freeze", host_rd_data, 16'h4000);
        freeze = 0;
        t = 0;
        done = 0;
        fork
            begin
                repeat (2) @(negedge cpu_clk);
                host_write(16'h8000);
                @(negedge cpu_clk);
                while (host_wr_busy) @(negedge cpu_clk);
                done = 1;
            end
            begin
                @(negedge bit_clk);
                bit_tick = 1;
                while (!done) begin
                    @(negedge bit_clk);
                    t++;
                end
                bit_tick = 0;
            end
        join
        settle();
        r = host_rd_data;
        chk("R9 load over tick", ((r - 16'h8000) < 16'(t)) ? 1 : 0, 1);
        exp_cnt = r;
    endtask

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge cpu_clk);
        cpu_rst_n = 1;
        bit_rst_n = 1;
        repeat (4) @(negedge bit_clk);
        t_reset();
        t_count();
        t_freeze();
        t_write();
        t_wrap();
        t_stamp();
        t_load_prio();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule